// File: doc/BRIEF.md
# Processor Reset and Boot-Address Sequencer

This block governs a 32-bit processor core around reset. While the reset input is high, it keeps instruction fetch and bus activity switched off. All architectural outputs stay cleared during that time. The reset input is brought into the clock domain through a two-stage synchroniser. It asserts asynchronously and releases synchronously.

After the synchronised release, a timer counts a fixed start delay of `START_DELAY` cycles. The elaboration step accepts the delay only if it lies between 350 and 450. When the delay ends, the block loads the initial architectural register values and enables fetch. The code segment starts with a base near the top of the 4 GB space, so the first fetch address is 0xFFFFFFF0. The upper address lines stay forced high for code-relative cycles until the core reports its first far jump or far call. From that point the force is dropped, and it stays dropped until the next reset.

The sequencer is one state machine with four states:
- `ST_HOLD` is entered whenever the synchronised reset is active.
- `ST_HOLD` always moves to `ST_COUNT` on the first clock edge after release.
- `ST_COUNT` moves to `ST_BOOT` when the delay timer signals completion, and the registers load on that same edge.
- `ST_BOOT` moves to `ST_FLAT` when a far transfer is reported.
- `ST_FLAT` has no exit except reset.

Top module: `boot_seq`

## Requirements
- R1: While `rst_in` is high, `fetch_en` is 0, `addr_hi_force` is 1, and every register output and `fetch_addr` read zero. This takes effect without waiting for a clock edge.
- R2: After `rst_in` falls, `fetch_en` is still 0 after the (START_DELAY+1)-th rising edge. It becomes 1 on the (START_DELAY+2)-th rising edge (two synchroniser edges plus the delay), and stays 1 until reset.
- R3: When `fetch_en` rises, the outputs take these values: `eip` = 0x0000FFF0, `cs_sel` = 0xF000, `cs_base` = 0xFFFF0000, `cs_limit` = 0x0000FFFF and `fetch_addr` = 0xFFFFFFF0. All of these stay stable while `fetch_en` is high.
- R4: When `fetch_en` rises, `ds_sel`, `ss_sel`, `es_sel`, `fs_sel` and `gs_sel` are 0x0000, and `eflags` is 0x00000002 (only bit 1 set, bits 16 and 17 clear).
- R5: When `fetch_en` rises, bit 4 of `cr0` equals `copro_new` as sampled on the load edge (1 = newer coprocessor type), and every other `cr0` bit is 0.
- R6: When `fetch_en` rises, `edx` equals the parameter `ID_CODE`. `eax` equals `selftest_sig` sampled on the load edge if `selftest_req` was 1 at that edge, and 0 otherwise.
- R7: `addr_hi_force` stays 1 from reset until the first far transfer taken while `fetch_en` is 1. A `far_xfer` pulse while `fetch_en` is 0 has no effect.
- R8: A `far_xfer` pulse taken while `fetch_en` is 1 drives `addr_hi_force` to 0 from the next rising edge. It stays 0 until reset, whatever further `far_xfer` pulses arrive.
- R9: Raising `rst_in` at any point returns the block to the R1 state, both during the delay count and while running. The next release restarts the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_in | input | 1 | Asynchronous reset, active high |
| copro_new | input | 1 | Coprocessor strap: 1 for newer type, 0 for older or absent |
| selftest_req | input | 1 | Self-test was requested for this reset |
| selftest_sig | input | 32 | Self-test result signature |
| far_xfer | input | 1 | Core executed a far jump or far call this cycle |
| fetch_en | output | 1 | Instruction fetch and bus activity allowed |
| addr_hi_force | output | 1 | Force address bits 31:20 high on code-relative cycles |
| fetch_addr | output | 32 | First fetch address (code base plus instruction pointer) |
| eip | output | 32 | Initial instruction pointer |
| cs_sel | output | 16 | Initial code segment selector |
| cs_base | output | 32 | Initial hidden code segment base |
| cs_limit | output | 32 | Initial hidden code segment limit |
| ds_sel | output | 16 | Initial data segment selector |
| ss_sel | output | 16 | Initial stack segment selector |
| es_sel | output | 16 | Initial first extra segment selector |
| fs_sel | output | 16 | Initial second extra segment selector |
| gs_sel | output | 16 | Initial third extra segment selector |
| eflags | output | 32 | Initial flags register |
| cr0 | output | 32 | Initial control register |
| edx | output | 32 | Component and stepping identifier |
| eax | output | 32 | Self-test signature or zero |

## Verification
The bench sweeps all four combinations of the coprocessor strap and the self-test request, each with a different signature. This separates the `cr0` bit-4 path from the `eax` selection. In every boot the bench counts edges from reset release and samples on both sides of the enabling edge, which pins down the synchroniser depth and the delay exactly. Far-transfer pulses are issued once during the count and twice after fetch is enabled, to distinguish an ignored pulse, the first pulse that clears the force, and a later one that must not bring it back. A reset raised partway through the count shows that the delay restarts from zero.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_BOOT  = 2'd2,
        ST_FLAT  = 2'd3
    } boot_state_e;

    localparam logic [31:0] EIP_INIT      = 32'h0000_FFF0;
    localparam logic [15:0] CS_SEL_INIT   = 16'hF000;
    localparam logic [31:0] CS_BASE_INIT  = 32'hFFFF_0000;
    localparam logic [31:0] CS_LIMIT_INIT = 32'h0000_FFFF;
    localparam logic [31:0] EFLAGS_INIT   = 32'h0000_0002;
    localparam int          CR0_ET_POS    = 4;
    localparam int          DELAY_MIN     = 350;
    localparam int          DELAY_MAX     = 450;

    typedef struct packed {
        logic [31:0] eip;
        logic [15:0] cs_sel;
        logic [31:0] cs_base;
        logic [31:0] cs_limit;
        logic [15:0] ds_sel;
        logic [15:0] ss_sel;
        logic [15:0] es_sel;
        logic [15:0] fs_sel;
        logic [15:0] gs_sel;
        logic [31:0] eflags;
        logic [31:0] cr0;
        logic [31:0] edx;
        logic [31:0] eax;
    } arch_state_t;

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b0};
        end
    end

    assign rst_out = chain_q[STAGES-1];
endmodule

// File: rtl/boot_delay_timer.sv
module boot_delay_timer #(
    parameter int START_DELAY = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(START_DELAY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(START_DELAY - 2);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (!run) begin
            cnt_q <= '0;
        end
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/boot_arch_init.sv
module boot_arch_init
    import boot_pkg::*;
#(
    parameter logic [31:0] ID_CODE = 32'h0000_0A5C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic        copro_new,
    input  logic        selftest_req,
    input  logic [31:0] selftest_sig,
    output arch_state_t arch
);
    arch_state_t init_val;

    always_comb begin
        init_val          = '0;
        init_val.eip      = EIP_INIT;
        init_val.cs_sel   = CS_SEL_INIT;
        init_val.cs_base  = CS_BASE_INIT;
        init_val.cs_limit = CS_LIMIT_INIT;
        init_val.eflags   = EFLAGS_INIT;
        init_val.cr0[CR0_ET_POS] = copro_new;
        init_val.edx      = ID_CODE;
        init_val.eax      = selftest_req ? selftest_sig : 32'h0;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            arch <= '0;
        end else if (load) begin
            arch <= init_val;
        end
    end
endmodule

// File: rtl/boot_seq.sv
module boot_seq
    import boot_pkg::*;
#(
    parameter int          START_DELAY = 400,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] ID_CODE     = 32'h0000_0A5C
) (
    input  logic        clk,
    input  logic        rst_in,
    input  logic        copro_new,
    input  logic        selftest_req,
    input  logic [31:0] selftest_sig,
    input  logic        far_xfer,
    output logic        fetch_en,
    output logic        addr_hi_force,
    output logic [31:0] fetch_addr,
    output logic [31:0] eip,
    output logic [15:0] cs_sel,
    output logic [31:0] cs_base,
    output logic [31:0] cs_limit,
    output logic [15:0] ds_sel,
    output logic [15:0] ss_sel,
    output logic [15:0] es_sel,
    output logic [15:0] fs_sel,
    output logic [15:0] gs_sel,
    output logic [31:0] eflags,
    output logic [31:0] cr0,
    output logic [31:0] edx,
    output logic [31:0] eax
);
    if (START_DELAY < DELAY_MIN || START_DELAY > DELAY_MAX) begin : g_bad_delay
        $error("boot_seq: START_DELAY out of the 350..450 window");
    end
    if (SYNC_STAGES < 2) begin : g_bad_sync
        $error("boot_seq: SYNC_STAGES must be at least 2");
    end

    logic        rst_sync;
    logic        delay_done;
    logic        load;
    arch_state_t arch;

    boot_state_e state_q;
    boot_state_e state_d;

    boot_rst_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_in  (rst_in),
        .rst_out (rst_sync)
    );

    boot_delay_timer #(
        .START_DELAY (START_DELAY)
    ) u_timer (
        .clk  (clk),
        .rst  (rst_sync),
        .run  (state_q == ST_COUNT),
        .done (delay_done)
    );

    boot_arch_init #(
        .ID_CODE (ID_CODE)
    ) u_init (
        .clk          (clk),
        .rst          (rst_sync),
        .load         (load),
        .copro_new    (copro_new),
        .selftest_req (selftest_req),
        .selftest_sig (selftest_sig),
        .arch         (arch)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = ST_COUNT;
            ST_COUNT: if (delay_done) state_d = ST_BOOT;
            ST_BOOT:  if (far_xfer)   state_d = ST_FLAT;
            ST_FLAT:  state_d = ST_FLAT;
            default:  state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or posedge rst_sync) begin
        if (rst_sync) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load          = 1'b0;
        fetch_en      = 1'b0;
        addr_hi_force = 1'b1;
        unique case (state_q)
            ST_HOLD:  ;
            ST_COUNT: load = delay_done;
            ST_BOOT:  fetch_en = 1'b1;
            ST_FLAT: begin
                fetch_en      = 1'b1;
                addr_hi_force = 1'b0;
            end
            default:  ;
        endcase
    end

    assign eip        = arch.eip;
    assign cs_sel     = arch.cs_sel;
    assign cs_base    = arch.cs_base;
    assign cs_limit   = arch.cs_limit;
    assign ds_sel     = arch.ds_sel;
    assign ss_sel     = arch.ss_sel;
    assign es_sel     = arch.es_sel;
    assign fs_sel     = arch.fs_sel;
    assign gs_sel     = arch.gs_sel;
    assign eflags     = arch.eflags;
    assign cr0        = arch.cr0;
    assign edx        = arch.edx;
    assign eax        = arch.eax;
    assign fetch_addr = arch.cs_base + arch.eip;
endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker (
    input logic        clk,
    input logic        rst_in,
    input logic        far_xfer,
    input logic        fetch_en,
    input logic        addr_hi_force,
    input logic [31:0] fetch_addr,
    input logic [31:0] eip,
    input logic [31:0] cr0,
    input logic [31:0] eflags
);
    // R1: no fetch while reset is held
    a_r1_hold_off: assert property (@(posedge clk)
        rst_in |-> (!fetch_en && addr_hi_force));

    // R2: once enabled, fetch stays enabled until reset
    a_r2_fetch_sticky: assert property (@(posedge clk) disable iff (rst_in)
        fetch_en |=> fetch_en);

    // R3: first fetch near the top of memory, state frozen while running
    a_r3_top_fetch: assert property (@(posedge clk) disable iff (rst_in)
        fetch_en |-> (fetch_addr == 32'hFFFF_FFF0));

    a_r3_state_stable: assert property (@(posedge clk) disable iff (rst_in)
        fetch_en |=> ($stable(eip) && $stable(cr0) && $stable(eflags)));

    // R7: force cannot drop before fetch is enabled
    a_r7_force_before_run: assert property (@(posedge clk) disable iff (rst_in)
        !fetch_en |-> addr_hi_force);

    // R8: a far transfer while running clears the force next cycle
    a_r8_far_clears: assert property (@(posedge clk) disable iff (rst_in)
        (fetch_en && addr_hi_force && far_xfer) |=> !addr_hi_force);

    // R8: once cleared, the force stays cleared until reset
    a_r8_flat_sticky: assert property (@(posedge clk) disable iff (rst_in)
        !addr_hi_force |=> !addr_hi_force);
endmodule

bind boot_seq boot_seq_checker u_chk (
    .clk           (clk),
    .rst_in        (rst_in),
    .far_xfer      (far_xfer),
    .fetch_en      (fetch_en),
    .addr_hi_force (addr_hi_force),
    .fetch_addr    (fetch_addr),
    .eip           (eip),
    .cr0           (cr0),
    .eflags        (eflags)
);

// File: tb/boot_seq_bench.sv
`timescale 1ns/1ps
module boot_seq_bench;
    localparam int          D    = 400;
    localparam logic [31:0] IDC  = 32'h0000_0A5C;

    logic        clk = 1'b0;
    logic        rst_in = 1'b1;
    logic        copro_new = 1'b0;
    logic        selftest_req = 1'b0;
    logic [31:0] selftest_sig = 32'h0;
    logic        far_xfer = 1'b0;
    logic        fetch_en, addr_hi_force;
    logic [31:0] fetch_addr, eip, cs_base, cs_limit, eflags, cr0, edx, eax;
    logic [15:0] cs_sel, ds_sel, ss_sel, es_sel, fs_sel, gs_sel;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    boot_seq #(.START_DELAY(D), .SYNC_STAGES(2), .ID_CODE(IDC)) u_boot_seq (
        .clk(clk), .rst_in(rst_in), .copro_new(copro_new),
        .selftest_req(selftest_req), .selftest_sig(selftest_sig),
        .far_xfer(far_xfer), .fetch_en(fetch_en), .addr_hi_force(addr_hi_force),
        .fetch_addr(fetch_addr), .eip(eip), .cs_sel(cs_sel), .cs_base(cs_base),
        .cs_limit(cs_limit), .ds_sel(ds_sel), .ss_sel(ss_sel), .es_sel(es_sel),
        .fs_sel(fs_sel), .gs_sel(gs_sel), .eflags(eflags), .cr0(cr0),
        .edx(edx), .eax(eax)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_cleared(input string req);
        chk(req, {31'b0, fetch_en}, 32'd0);
        chk(req, {31'b0, addr_hi_force}, 32'd1);
        chk(req, eip | cs_base | cs_limit | eflags | cr0 | edx | eax | fetch_addr, 32'd0);
        chk(req, {16'b0, cs_sel | ds_sel | ss_sel | es_sel | fs_sel | gs_sel}, 32'd0);
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic boot(input logic cp, input logic st, input logic [31:0] sig,
                        input logic early_far);
        @(negedge clk);
        rst_in = 1'b1;
        #1;
        check_cleared("R1/R9 async");
        copro_new = cp; selftest_req = st; selftest_sig = sig;
        wait_neg(3);
        check_cleared("R1");
        rst_in = 1'b0;
        for (int k = 1; k <= D + 1; k++) begin
            @(negedge clk);
            if (early_far && k == 100) far_xfer = 1'b1;
            if (early_far && k == 101) far_xfer = 1'b0;
        end
        chk("R2 low before edge", {31'b0, fetch_en}, 32'd0);
        @(negedge clk);
        chk("R2 high on edge", {31'b0, fetch_en}, 32'd1);
        chk("R3 eip", eip, 32'h0000_FFF0);
        chk("R3 cs_sel", {16'b0, cs_sel}, 32'h0000_F000);
        chk("R3 cs_base", cs_base, 32'hFFFF_0000);
        chk("R3 cs_limit", cs_limit, 32'h0000_FFFF);
        chk("R3 fetch_addr", fetch_addr, 32'hFFFF_FFF0);
        chk("R4 data selectors", {16'b0, ds_sel | ss_sel | es_sel | fs_sel | gs_sel}, 32'd0);
        chk("R4 eflags", eflags, 32'h0000_0002);
        chk("R5 cr0", cr0, {27'b0, cp, 4'b0});
        chk("R6 edx", edx, IDC);
        chk("R6 eax", eax, st ? sig : 32'h0);
        chk("R7 force held after boot", {31'b0, addr_hi_force}, 32'd1);
        wait_neg(5);
        chk("R7 force held while running", {31'b0, addr_hi_force}, 32'd1);
        far_xfer = 1'b1;
        @(negedge clk);
        far_xfer = 1'b0;
        chk("R8 force cleared", {31'b0, addr_hi_force}, 32'd0);
        wait_neg(2);
        far_xfer = 1'b1;
        @(negedge clk);
        far_xfer = 1'b0;
        wait_neg(2);
        chk("R8 force stays cleared", {31'b0, addr_hi_force}, 32'd0);
        chk("R2 fetch still on", {31'b0, fetch_en}, 32'd1);
        chk("R3 eip stable", eip, 32'h0000_FFF0);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1;
        check_cleared("R1 time zero");
        // R9: reset raised partway through the delay count
        wait_neg(2);
        rst_in = 1'b0;
        wait_neg(150);
        chk("R9 no fetch mid count", {31'b0, fetch_en}, 32'd0);
        rst_in = 1'b1;
        #1;
        check_cleared("R9 reset mid count");
        // sweep straps and self-test request
        for (int c = 0; c < 4; c++) begin
            boot(c[0], c[1], 32'hA5A5_0000 + 32'(c * 32'h1111), c[0] ^ c[1]);
        end
        boot(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule